// File: doc/BRIEF.md
# Configurable SPI Master Port

This block is an 8-bit SPI master. The host starts a transfer by writing a byte on the write strobe while the port is idle. The port then drives a serial clock at one of four selectable rates. It shifts the byte out on the serial data output and, at the same time, shifts a byte in from the serial data input. Both directions carry the most significant bit first. Three settings shape each transfer: the clock idle level, whether output data leads or coincides with the first clock edge, and whether input data is sampled in the middle or at the end of each bit. All three settings and the rate are captured at the moment the write is accepted.

A finished byte goes into a receive buffer, which the host drains over a valid/ready interface. `rx_valid` rises when a byte is loaded and stays high, with `rx_data` held steady, until the host asserts `rx_ready`. A byte that completes while the buffer is still unread is dropped and raises a sticky overflow flag. The host write side is a plain strobe with no back-pressure: a write made during a transfer is discarded and flagged as a collision. The output enable of the data pin can be switched off for receive-only use. In that case the port still clocks and samples, so it can watch a line without driving it.

Top module: `spim_top`

## Requirements
- R1: A write (`wr_en`=1) while `busy`=0 starts a transfer, and `busy` is 1 from the next cycle. `sdo` presents `wr_data` bit 7 first, then bit 6 down to bit 0. Each bit is held for two consecutive half-bit phases (phases 2i and 2i+1 carry data bit 7-i). `sdo` is 0 after reset and after a transfer.
- R2: The rate code `cfg_rate` selects the bit period: 0 gives 4 clocks per bit, 1 gives 16, 2 gives 64, and 3 gives two `tmr_tick` pulses per bit (one pulse per half-bit phase). In the fixed-rate codes, the half-bit phase h of a transfer whose write was taken at clock edge 0 spans cycles h*H to h*H+H-1, where H is half the bit period. `busy` falls at clock edge 16*H.
- R3: While idle, `sck` equals `cfg_cpol` (0 = low, 1 = high). It returns to that level after every byte.
- R4: With `cfg_early`=1, `sck` is at its idle level in the even half-bit phases and active in the odd ones, so `sdo` is valid before the first edge. With `cfg_early`=0, `sck` is active in the even phases and idle in the odd ones, so the first edge comes with the first data bit.
- R5: With `cfg_smp_end`=0, `sdi` is sampled at the end of each even half-bit phase (mid-bit). With 1, it is sampled at the end of each odd phase (end of bit). The first sample becomes bit 7 of the received byte.
- R6: At the edge where `busy` falls, the received byte is written to `rx_data` and `rx_valid` and the sticky `irq` become 1.
- R7: While `rx_valid`=1 and `rx_ready`=0, `rx_valid` and `rx_data` hold. A cycle with both at 1 consumes the byte, and `rx_valid` is 0 afterwards unless a new byte loads at the same edge.
- R8: If a byte completes while `rx_valid`=1 and `rx_ready`=0, the sticky `ovf` becomes 1 and `rx_data` keeps the old byte. If `rx_ready`=1 in that same cycle, the new byte loads, `rx_valid` stays 1 and `ovf` is not set.
- R9: A write while `busy`=1 sets the sticky `wcol` and has no effect on the running transfer's waveform or received byte.
- R10: `flags_clr` clears `irq`, `wcol` and `ovf`. An event that sets a flag in the same cycle takes precedence.
- R11: `sdo_oe` follows `cfg_tx_en`. With it at 0, transfers run and receive exactly as with it at 1.
- R12: After reset, `busy`, `rx_valid`, `irq`, `wcol`, `ovf` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_early | input | 1 | 1: data leads first clock edge; 0: data changes on it |
| cfg_smp_end | input | 1 | 0: sample mid-bit; 1: sample at end of bit |
| cfg_rate | input | 2 | Bit-rate select (see R2) |
| cfg_tx_en | input | 1 | Data output enable |
| tmr_tick | input | 1 | Single-cycle timer pulse for rate code 3 |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_ready | input | 1 | Host takes the buffered byte |
| rx_data | output | 8 | Receive buffer |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky byte-complete flag |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive-overflow flag |
| flags_clr | input | 1 | Clears irq, wcol, ovf |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in |

## Verification
Two events can land in the same cycle: the completion of a byte and the host taking the previous one. A flag clear can also coincide with the completion that sets `irq`. The bench provokes both by running a transfer while the previous byte is still unread. It asserts `rx_ready` and `flags_clr` exactly in the last cycle before the completing edge, a cycle it knows from the rate. It then judges that the old byte was presented during the handshake cycle, and that afterwards the new byte is buffered with `rx_valid` still high, `ovf` clear and `irq` set.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    RATE_DIV_A = 2'd0,
    RATE_DIV_B = 2'd1,
    RATE_DIV_C = 2'd2,
    RATE_TMR   = 2'd3
  } rate_e;

  typedef struct packed {
    logic  cpol;
    logic  early;
    logic  smp_end;
    rate_e rate;
  } xfer_cfg_t;
endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen
  import spim_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  tmr_tick,
  output logic  half_tick
);
  localparam int HALF_A = DIV_A / 2;
  localparam int HALF_B = DIV_B / 2;
  localparam int HALF_C = DIV_C / 2;
  localparam int CW     = (HALF_C > 2) ? $clog2(HALF_C) : 1;

  logic [CW-1:0] cnt, limit;

  always_comb begin
    unique case (rate)
      RATE_DIV_A: limit = CW'(HALF_A - 1);
      RATE_DIV_B: limit = CW'(HALF_B - 1);
      default:    limit = CW'(HALF_C - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!run || rate == RATE_TMR)  cnt <= '0;
    else if (cnt == limit)              cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  assign half_tick = run && ((rate == RATE_TMR) ? tmr_tick : (cnt == limit));

  // R2: the prescale count never passes the selected half-bit length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rate != RATE_TMR) |-> (cnt <= limit));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  xfer_cfg_t       cfg_in,
  input  logic            half_tick,
  input  logic            sdi,
  output logic            busy,
  output xfer_cfg_t       cfg_q,
  output logic            sck,
  output logic            sdo,
  output logic            done,
  output logic [BITS-1:0] rx_byte
);
  localparam int PHASES = 2 * BITS;
  localparam int PW     = $clog2(PHASES);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

  logic [PW-1:0]   ph;
  logic [BITS-1:0] tx_sr, rx_sr, rx_in;
  logic            active;

  assign rx_in = {rx_sr[BITS-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph    <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      cfg_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      ph    <= '0;
      tx_sr <= tx_byte;
      cfg_q <= cfg_in;
    end else if (busy && half_tick) begin
      ph <= ph + 1'b1;
      if (!ph[0]) begin
        if (!cfg_q.smp_end) rx_sr <= rx_in;
      end else begin
        if (cfg_q.smp_end) rx_sr <= rx_in;
        tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        if (ph == PH_LAST) busy <= 1'b0;
      end
    end
  end

  assign done    = busy && half_tick && (ph == PH_LAST);
  assign rx_byte = cfg_q.smp_end ? rx_in : rx_sr;
  assign active  = cfg_q.early ? ph[0] : ~ph[0];
  assign sck     = busy ? (cfg_q.cpol ^ active) : cfg_in.cpol;
  assign sdo     = tx_sr[BITS-1];

  // R1: a start is followed by a busy port
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R1: data only moves at bit boundaries, never at mid-bit
  a_r1_sdo_mid_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_tick && !ph[0]) |=> $stable(sdo));
  // R6: the completing phase ends the transfer
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/spim_rxbuf.sv
module spim_rxbuf #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            rx_ready,
  input  logic            collide,
  input  logic            flags_clr,
  output logic            rx_valid,
  output logic [BITS-1:0] rx_data,
  output logic            irq,
  output logic            wcol,
  output logic            ovf
);
  logic take, lost;

  assign take = rx_valid && rx_ready;
  assign lost = load && rx_valid && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (load && !lost) begin
      rx_valid <= 1'b1;
      rx_data  <= load_data;
    end else if (take) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      wcol <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      irq  <= load    | (irq  & ~flags_clr);
      wcol <= collide | (wcol & ~flags_clr);
      ovf  <= lost    | (ovf  & ~flags_clr);
    end
  end

  // R7: an unread byte is held until taken
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !load) |=> (rx_valid && $stable(rx_data)));
  // R8: a byte arriving on a full buffer is dropped and flagged
  a_r8_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rx_valid && !rx_ready) |=> (ovf && $stable(rx_data)));
  // R10: a set event beats a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> irq);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_early,
  input  logic            cfg_smp_end,
  input  logic [1:0]      cfg_rate,
  input  logic            cfg_tx_en,
  input  logic            tmr_tick,
  input  logic            wr_en,
  input  logic [BITS-1:0] wr_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [BITS-1:0] rx_data,
  output logic            busy,
  output logic            irq,
  output logic            wcol,
  output logic            ovf,
  input  logic            flags_clr,
  output logic            sck,
  output logic            sdo,
  output logic            sdo_oe,
  input  logic            sdi
);
  xfer_cfg_t       cfg_in, cfg_q;
  logic            start, collide, half_tick, done;
  logic [BITS-1:0] rx_byte;

  assign cfg_in  = '{cpol: cfg_cpol, early: cfg_early, smp_end: cfg_smp_end,
                     rate: rate_e'(cfg_rate)};
  assign start   = wr_en && !busy;
  assign collide = wr_en && busy;
  assign sdo_oe  = cfg_tx_en;

  spim_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(cfg_q.rate),
    .tmr_tick(tmr_tick), .half_tick(half_tick)
  );

  spim_engine #(.BITS(BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(wr_data),
    .cfg_in(cfg_in), .half_tick(half_tick), .sdi(sdi), .busy(busy),
    .cfg_q(cfg_q), .sck(sck), .sdo(sdo), .done(done), .rx_byte(rx_byte)
  );

  spim_rxbuf #(.BITS(BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(done), .load_data(rx_byte),
    .rx_ready(rx_ready), .collide(collide), .flags_clr(flags_clr),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq), .wcol(wcol), .ovf(ovf)
  );

  // R9: a write during a transfer is flagged
  a_r9_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);
  // R3: with no transfer running the clock rests at its idle level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (busy || sck == cfg_cpol));
endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 0, cfg_early = 0, cfg_smp_end = 0, cfg_tx_en = 1;
  logic [1:0] cfg_rate = 0;
  logic tmr_tick = 0, wr_en = 0, rx_ready = 0, flags_clr = 0, sdi = 0;
  logic [7:0] wr_data = 0;
  logic rx_valid, busy, irq, wcol, ovf, sck, sdo, sdo_oe;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_buf = 0;
  bit exp_valid = 0, exp_irq = 0, exp_wcol = 0, exp_ovf = 0;
  int salt = 0;
  localparam logic [63:0] PAT = 64'hD1B5_4A32_9C6E_F087;

  always #5 clk = ~clk;

  spim_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_early(cfg_early),
    .cfg_smp_end(cfg_smp_end), .cfg_rate(cfg_rate), .cfg_tx_en(cfg_tx_en),
    .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy), .irq(irq), .wcol(wcol),
    .ovf(ovf), .flags_clr(flags_clr), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdi(sdi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pat_bit(input int c);
    return PAT[c % 64] ^ ((c / 64) % 2 == 1) ^ (salt % 2 == 1);
  endfunction

  task automatic reset_check();
    @(negedge clk);
    chk("R12 busy", busy, 0);     chk("R12 rx_valid", rx_valid, 0);
    chk("R12 irq", irq, 0);       chk("R12 wcol", wcol, 0);
    chk("R12 ovf", ovf, 0);       chk("R12 sdo", sdo, 0);
    chk("R3 idle sck", sck, cfg_cpol);
  endtask

  // One fixed-rate transfer with optional collision, read and clear cycles.
  task automatic run_xfer(input int rate, input bit cpol, input bit early,
                          input bit smp_end, input bit txen, input logic [7:0] d,
                          input int coll_at, input int read_at, input int clr_at);
    int h_len, n, sck_err, sdo_err, busy_err;
    logic [7:0] exp_rx;
    bit lost;
    h_len = (rate == 0) ? 2 : (rate == 1) ? 8 : 32;
    n = 16 * h_len;
    sck_err = 0; sdo_err = 0; busy_err = 0;
    salt++;
    for (int i = 0; i < 8; i++)
      exp_rx[7-i] = pat_bit(smp_end ? (2*i+2)*h_len - 1 : (2*i+1)*h_len - 1);
    @(negedge clk);
    cfg_rate = 2'(rate); cfg_cpol = cpol; cfg_early = early;
    cfg_smp_end = smp_end; cfg_tx_en = txen; wr_en = 1; wr_data = d;
    @(posedge clk);
    for (int c = 0; c < n; c++) begin
      int h;
      @(negedge clk);
      h = c / h_len;
      wr_en = (c == coll_at); wr_data = (c == coll_at) ? ~d : d;
      rx_ready = (c == read_at); flags_clr = (c == clr_at);
      sdi = pat_bit(c);
      if (sck !== (cpol ^ (early ? (h % 2 == 1) : (h % 2 == 0)))) sck_err++;
      if (sdo !== d[7 - h/2]) sdo_err++;
      if (busy !== 1'b1) busy_err++;
      if (c == read_at) begin
        chk("R8 old byte at handshake", rx_data, exp_buf);
        chk("R7 valid at handshake", rx_valid, 1);
      end
    end
    @(negedge clk);
    wr_en = 0; rx_ready = 0; flags_clr = 0;
    chk("R4 sck waveform mismatches", sck_err, 0);
    chk("R1 sdo waveform mismatches", sdo_err, 0);
    chk("R2 busy through 16 half-bits", busy_err, 0);
    chk("R2 busy falls at edge 16H", busy, 0);
    chk("R3 sck back to idle", sck, cpol);
    chk("R1 sdo low after byte", sdo, 0);
    chk("R11 sdo_oe follows enable", sdo_oe, txen);
    lost = exp_valid && (read_at < 0);
    if (clr_at >= 0) begin exp_wcol = 0; exp_ovf = 0; end
    if (coll_at >= 0) exp_wcol = 1;
    if (lost) exp_ovf = 1; else exp_buf = exp_rx;
    exp_valid = 1; exp_irq = 1;
    chk("R5 received byte", rx_data, exp_buf);
    chk("R6 rx_valid", rx_valid, 1);
    chk("R6 irq", irq, exp_irq);
    chk("R8 ovf", ovf, exp_ovf);
    chk("R9 wcol", wcol, exp_wcol);
  endtask

  task automatic read_buf();
    logic [7:0] held;
    @(negedge clk);
    held = rx_data;
    repeat (4) @(negedge clk);
    chk("R7 valid held", rx_valid, 1);
    chk("R7 data held", rx_data, held);
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
    chk("R7 valid drops after take", rx_valid, 0);
    exp_valid = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flags_clr = 1;
    @(negedge clk); flags_clr = 0;
    chk("R10 irq cleared", irq, 0);
    chk("R10 wcol cleared", wcol, 0);
    chk("R10 ovf cleared", ovf, 0);
    exp_irq = 0; exp_wcol = 0; exp_ovf = 0;
  endtask

  task automatic run_timer(input logic [7:0] d);
    logic [7:0] exp_rx;
    salt++;
    for (int i = 0; i < 8; i++) exp_rx[7-i] = pat_bit(2*i);
    @(negedge clk);
    cfg_rate = 2'd3; cfg_cpol = 0; cfg_early = 1; cfg_smp_end = 0; cfg_tx_en = 1;
    wr_en = 1; wr_data = d;
    @(posedge clk);
    for (int t = 0; t < 16; t++) begin
      @(negedge clk); wr_en = 0; sdi = pat_bit(t);
      repeat (2) @(negedge clk);
      if (t == 15) chk("R2 timer: busy before 16th tick", busy, 1);
      tmr_tick = 1;
      @(negedge clk); tmr_tick = 0;
    end
    chk("R2 timer: done after 16 ticks", busy, 0);
    chk("R5 timer received byte", rx_data, exp_rx);
    exp_buf = exp_rx; exp_valid = 1; exp_irq = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    reset_check();
    run_xfer(0, 0, 1, 0, 1, 8'hA5, -1, -1, -1); read_buf();
    run_xfer(1, 1, 0, 1, 1, 8'h3C, -1, -1, -1); read_buf();
    run_xfer(2, 0, 0, 1, 1, 8'h81, -1, -1, -1); read_buf();
    run_xfer(0, 1, 1, 0, 0, 8'h5A, -1, -1, -1); read_buf();
    run_xfer(0, 0, 1, 1, 1, 8'hC3, 7, -1, -1);
    clear_flags(); read_buf();
    run_xfer(0, 0, 0, 0, 1, 8'hE1, -1, -1, -1);
    run_xfer(1, 0, 1, 0, 1, 8'h17, -1, -1, -1);
    clear_flags(); read_buf();
    run_xfer(0, 0, 1, 0, 1, 8'h99, -1, -1, -1);
    run_xfer(0, 1, 0, 1, 1, 8'h66, -1, 31, 31);
    clear_flags(); read_buf();
    run_timer(8'h4B); read_buf();
    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule